// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns the nibble stream from a 100 Mb/s MAC into a three-level line signal for a twisted-pair link. On every nibble strobe it reads a 4-bit data nibble together with its transmit-enable and transmit-error qualifiers. It picks a 5-bit line code, which is either a 4B/5B data code or a framing code (idle, start pair, end pair or error). It then shifts that code out one bit per 125 MHz bit clock.

Each code bit is XORed with one keystream bit from an 11-bit scrambler. The scrambled stream is NRZI-coded, and every NRZI transition advances a four-phase MLT3 sequencer. The sequencer drives a signed 2-bit line level. The strobe is supplied from outside and must fire exactly once every five bit clocks. All state uses an asynchronous active-low reset.

Top module: `fe_line_encoder`

## Requirements
- R1: While reset is asserted and right after it is released, `line_lvl` is 0. Reset also puts the framing logic in the idle state, sets the NRZI level and MLT3 phase to 0, and loads the shift register with 11111.
- R2: In a frame's data slot with the error qualifier low, the nibble is sent as its 4B/5B code. The codes for nibbles 0 through F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R3: A strobe seen at a clock edge loads the slot's 5-bit code at that edge. The code is then sent leftmost bit first, one bit per clock. The first of its bits is scrambled and line-coded at the following edge, and the last at the next strobe edge. Between codes the shift register fills with 1s.
- R4: While no frame is in progress, every slot sends 11111. The data nibble and the error qualifier are ignored in those slots.
- R5: A strobe with transmit-enable high in the idle state sends 11000 in that slot and 10001 in the next slot, whatever the nibbles are. Data slots follow, even if enable has dropped in the second slot.
- R6: The first data slot in which transmit-enable is low sends 01101. The next slot sends 00111, and idle follows.
- R7: A data slot with both enable and error high sends 00100 in place of the nibble's code.
- R8: The keystream comes from an 11-bit register. At each clock its top bit is XORed onto the current code bit, and the register shifts up with (bit 10 XOR bit 8) entering at bit 0, which gives x^11 + x^9 + 1. Reset loads the nonzero value SEED (default 11'h4C5). The register never becomes zero.
- R9: The NRZI level toggles on each scrambled 1. Each toggle moves the MLT3 phase one step around 0, 1, 2, 3. Phase 1 drives +1 (2'b01), phase 3 drives -1 (2'b11), and phases 0 and 2 drive 0. A scrambled 0 holds the level.
- R10: `line_lvl` never takes the value 2'b10, and it never moves directly between +1 and -1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_stb | input | 1 | Nibble strobe, one clock in every five |
| tx_en | input | 1 | Transmit enable, sampled on the strobe |
| tx_er | input | 1 | Transmit error, sampled on the strobe |
| txd | input | 4 | Data nibble, sampled on the strobe |
| line_lvl | output | 2 | Signed line level: -1, 0 or +1 |

## Verification
On every clock, the embedded assertions check three things. The line level is one of the three legal values, and it never jumps between the extremes. A level change happens exactly when the NRZI level toggles. The keystream register never reaches zero, and the end-pair slot is always followed by idle. The code choice itself is only shown by the bench's scenarios: idle gaps with noise on the data and error inputs, start and end pairs, all sixteen data codes, error slots, and a frame whose enable drops during the start pair. The bench rebuilds the expected line level from the code bits, its own keystream and its own MLT3 phase.

// File: rtl/fe_line_encoder.sv
module fe_line_encoder #(
  parameter logic [10:0] SEED = 11'h4C5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_stb,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic [1:0] line_lvl
);

  localparam int CW = 5;
  localparam int LW = $bits(SEED);
  localparam int TAP = LW - 3;

  localparam logic [CW-1:0] C_IDLE = 5'b11111;
  localparam logic [CW-1:0] C_SSD1 = 5'b11000;
  localparam logic [CW-1:0] C_SSD2 = 5'b10001;
  localparam logic [CW-1:0] C_ESD1 = 5'b01101;
  localparam logic [CW-1:0] C_ESD2 = 5'b00111;
  localparam logic [CW-1:0] C_HALT = 5'b00100;

  typedef enum logic [1:0] {ST_IDLE, ST_SSD2, ST_DATA, ST_ESD2} fr_t;

  fr_t            fr_q, fr_d;
  logic [CW-1:0]  sh_q, code_d;
  logic [LW-1:0]  lfsr_q;
  logic           nrzi_q;
  logic [1:0]     ph_q;
  logic           scr_bit;

  function automatic logic [CW-1:0] enc4b5b(input logic [3:0] n);
    case (n)
      4'h0: enc4b5b = 5'b11110;
      4'h1: enc4b5b = 5'b01001;
      4'h2: enc4b5b = 5'b10100;
      4'h3: enc4b5b = 5'b10101;
      4'h4: enc4b5b = 5'b01010;
      4'h5: enc4b5b = 5'b01011;
      4'h6: enc4b5b = 5'b01110;
      4'h7: enc4b5b = 5'b01111;
      4'h8: enc4b5b = 5'b10010;
      4'h9: enc4b5b = 5'b10011;
      4'hA: enc4b5b = 5'b10110;
      4'hB: enc4b5b = 5'b10111;
      4'hC: enc4b5b = 5'b11010;
      4'hD: enc4b5b = 5'b11011;
      4'hE: enc4b5b = 5'b11100;
      default: enc4b5b = 5'b11101;
    endcase
  endfunction

  always_comb begin
    fr_d   = fr_q;
    code_d = C_IDLE;
    case (fr_q)
      ST_IDLE: if (tx_en) begin
        code_d = C_SSD1;
        fr_d   = ST_SSD2;
      end
      ST_SSD2: begin
        code_d = C_SSD2;
        fr_d   = ST_DATA;
      end
      ST_DATA: if (tx_en) begin
        code_d = tx_er ? C_HALT : enc4b5b(txd);
      end else begin
        code_d = C_ESD1;
        fr_d   = ST_ESD2;
      end
      default: begin
        code_d = C_ESD2;
        fr_d   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= ST_IDLE;
      sh_q <= C_IDLE;
    end else if (sym_stb) begin
      fr_q <= fr_d;
      sh_q <= code_d;
    end else begin
      sh_q <= {sh_q[CW-2:0], 1'b1};
    end
  end

  assign scr_bit = sh_q[CW-1] ^ lfsr_q[LW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      nrzi_q <= 1'b0;
      ph_q   <= 2'd0;
    end else begin
      lfsr_q <= {lfsr_q[LW-2:0], lfsr_q[LW-1] ^ lfsr_q[TAP]};
      nrzi_q <= nrzi_q ^ scr_bit;
      ph_q   <= ph_q + {1'b0, scr_bit};
    end
  end

  assign line_lvl = (ph_q == 2'd1) ? 2'b01 :
                    (ph_q == 2'd3) ? 2'b11 : 2'b00;

  // R8
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R10
  lvl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_lvl != 2'b10);

  // R10
  no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lvl != $past(line_lvl)) |-> (line_lvl == 2'b00 || $past(line_lvl) == 2'b00));

  // R9
  step_on_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nrzi_q != $past(nrzi_q)) == (line_lvl != $past(line_lvl)));

  // R6
  esd_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && fr_q == ST_ESD2) |=> (fr_q == ST_IDLE));

endmodule

// File: tb/fe_line_encoder_tb.sv
module fe_line_encoder_tb;
  localparam int CLK_NS = 8;
  localparam logic [10:0] SEED = 11'h4C5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_stb = 1'b0;
  logic tx_en = 1'b0;
  logic tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic [1:0] line_lvl;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit    q_bit[$];
  string q_tag[$];

  int m_fr = 0;
  logic [10:0] m_lfsr = SEED;
  logic [1:0]  m_ph = 2'd0;

  fe_line_encoder #(.SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb),
    .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .line_lvl(line_lvl)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [4:0] ref_code(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic logic [1:0] ph_lvl(input logic [1:0] p);
    return (p == 2'd1) ? 2'b01 : (p == 2'd3) ? 2'b11 : 2'b00;
  endfunction

  task automatic push_code(input logic [4:0] c, input string tag);
    for (int i = 4; i >= 0; i--) begin
      q_bit.push_back(c[i]);
      q_tag.push_back(tag);
    end
  endtask

  // Driver: one nibble slot; expected code from the framing rules (R2, R4-R7)
  task automatic slot(input logic en, input logic er, input logic [3:0] d);
    tx_en = en; tx_er = er; txd = d; sym_stb = 1'b1;
    case (m_fr)
      0: if (en) begin push_code(5'b11000, "R5 start-1"); m_fr = 1; end
         else push_code(5'b11111, "R4 idle");
      1: begin push_code(5'b10001, "R5 start-2"); m_fr = 2; end
      2: if (!en) begin push_code(5'b01101, "R6 end-1"); m_fr = 3; end
         else if (er) push_code(5'b00100, "R7 error");
         else push_code(ref_code(d), "R2 data");
      default: begin push_code(5'b00111, "R6 end-2"); m_fr = 0; end
    endcase
    @(posedge clk);
    #1 sym_stb = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  // Monitor: per edge consume one code bit, apply R8 keystream and R9 MLT3, compare (R3 timing)
  initial begin
    wait (rst_n);
    forever begin
      bit b, s;
      string t;
      @(posedge clk);
      if (done) break;
      if (q_bit.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R3: bit queue empty, actual=%0d expected=bit", line_lvl);
        continue;
      end
      b = q_bit.pop_front();
      t = q_tag.pop_front();
      s = b ^ m_lfsr[10];
      m_lfsr = {m_lfsr[9:0], m_lfsr[10] ^ m_lfsr[8]};
      m_ph = m_ph + {1'b0, s};
      @(negedge clk);
      n_cmp++;
      if (line_lvl !== ph_lvl(m_ph)) begin
        n_bad++;
        $display("FAIL %s (R9/R10 line level): actual=%b expected=%b at %0t",
                 t, line_lvl, ph_lvl(m_ph), $time);
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state, reset-value shift bit is consumed at the first edge
    q_bit.push_back(1'b1);
    q_tag.push_back("R1 reset bit");
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (line_lvl !== 2'b00) begin
      n_bad++;
      $display("FAIL R1: actual=%b expected=00", line_lvl);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R4: idle with noise on data and error inputs
    slot(0, 0, 4'h0);
    slot(0, 1, 4'h9);
    slot(0, 1, 4'hF);
    slot(0, 0, 4'h6);

    // Frame 1: start pair, all sixteen data codes, an error slot, end pair
    slot(1, 0, 4'h5);
    slot(1, 0, 4'h5);
    for (int n = 0; n < 16; n++) slot(1, 0, n[3:0]);
    slot(1, 1, 4'h3);
    slot(1, 0, 4'hA);
    slot(0, 0, 4'h0);
    slot(0, 1, 4'h7);
    slot(0, 0, 4'h0);

    // Frame 2: enable drops during start pair -> one data slot sends end-1
    slot(1, 1, 4'h2);
    slot(0, 0, 4'h0);
    slot(0, 0, 4'h0);
    slot(0, 0, 4'h0);
    slot(0, 0, 4'h0);

    // Frame 3: error on consecutive slots, back-to-back restart after idle
    slot(1, 0, 4'h5);
    slot(1, 0, 4'hD);
    slot(1, 1, 4'h0);
    slot(1, 1, 4'hF);
    slot(1, 0, 4'hE);
    slot(0, 0, 4'h0);
    slot(1, 0, 4'h1);
    slot(0, 0, 4'h0);
    slot(1, 0, 4'h4);
    slot(1, 0, 4'h4);
    slot(1, 0, 4'hB);
    slot(0, 0, 4'h0);

    // Long idle to run the scrambler past a full keystream period (R8)
    for (int k = 0; k < 420; k++) slot(0, k[0], k[3:0]);

    done = 1'b1;
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule